// File: doc/BRIEF.md
# Dual-Rail HDB3 Line Decoder

This block turns a bipolar line signal, given as two unipolar pulse rails (one per polarity) sampled on a single clock, into one NRZ bit stream. A pulse on either rail is a one and an empty bit period is a zero. The zero-substitution codes that the transmitter inserted are recognised and turned back into the four zeros they stand for. Wherever the line breaks the coding rules, the block raises a one-cycle alarm.

Substitution codes end with a pulse of the same polarity as the mark before it. That pulse can only be recognised after the bits it replaces have already been received. The decoder therefore holds every decoded bit in a short retiming pipe, so that the pattern can be rewritten before it leaves. The output has a fixed latency of four clocks. The alarm is registered straight from the classification stage and is not delayed by the pipe.

Top module: `hdb3_line_decoder`

## Requirements
- R1: `rst` is synchronous and active high. While it is held, `nrz_out` and `code_alarm` are low on the following clock.
- R2: Reset clears the record of the previous mark's polarity. The first single-rail pulse after reset is never treated as a violation: it decodes as one and raises no alarm.
- R3: `rail_p` high with `rail_n` low is a positive mark, `rail_n` high with `rail_p` low is a negative mark, and both low is a space. A mark that keeps the alternating rule decodes as 1 and a space decodes as 0. The bit sampled at rising edge n is driven on `nrz_out` from edge n+4 onward.
- R4: `code_alarm` is high for exactly the one clock period that follows the edge sampling an offending symbol, and low after every edge whose symbol is not an error.
- R5: A mark with the same polarity as the previous mark, preceded by exactly three spaces, is a substitution. It and the three spaces decode as 0000 and no alarm is raised.
- R6: A same-polarity mark preceded by exactly two spaces is also a substitution when the mark before those spaces was a rule-abiding alternating mark. That mark, the two spaces and the violating mark decode as 0000 with no alarm. If the mark before the two spaces was itself a violation or a double-rail symbol, the pattern is not a substitution and R7 applies.
- R7: A same-polarity mark that does not complete a substitution under R5 or R6 is a bipolar violation. It decodes as 1 and raises the alarm. A mark of opposite polarity to the previous mark never raises the alarm.
- R8: Both rails high in the same cycle is an illegal encoding. It decodes as 1, raises the alarm, and leaves the recorded polarity unchanged.
- R9: The space that makes a run of more than RUN_LIMIT (default 4) consecutive spaces raises the alarm once. Further spaces in the same run raise no alarm. Any mark ends the run, and so does a completed substitution.
- R10: Any NRZ stream that begins with a one and is encoded by standard HDB3 rules is reproduced bit for bit, with no alarm. The rules are: alternating marks; four zeros become 000V after an odd number of marks since the last substitution, or B00V after an even number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock; both rails are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rail_p | input | 1 | Positive pulse rail |
| rail_n | input | 1 | Negative pulse rail |
| nrz_out | output | 1 | Decoded NRZ data, four clocks after sampling |
| code_alarm | output | 1 | One-cycle pulse per detected coding error |

## Verification
The bench encodes all 1024 ten-bit words back to back, which walks the decoder through every mix of 000V and B00V substitutions and isolated zeros. A pipe that rewrote the wrong positions or had the wrong latency would corrupt bits at fixed offsets. A decoder that took the B of B00V for data would leave stray ones. Directed sequences then aim at the boundaries between legal and illegal codes:
- a violation after one space or after four spaces;
- two spaces after a substitution, where a decoder that accepts any two-space pattern would swallow a real error;
- the fifth versus the sixth space of a run, where a level alarm instead of a pulse would stay high;
- a double-rail symbol, which must not disturb the polarity record;
- a mark right after reset, where a stale polarity would fake a violation.

// File: rtl/hdb3_dec_pkg.sv
package hdb3_dec_pkg;

  // Encoding is {rail_n, rail_p}
  typedef enum logic [1:0] {
    SYM_SPACE  = 2'd0,
    SYM_PLUS   = 2'd1,
    SYM_MINUS  = 2'd2,
    SYM_DOUBLE = 2'd3
  } line_sym_t;

  typedef struct packed {
    logic mark_bit;  // decoded value pushed into the retiming pipe
    logic wipe;      // clear the substituted positions already in the pipe
    logic err;       // coding error seen on this symbol
  } dec_act_t;

endpackage

// File: rtl/hdb3_sym_classify.sv
module hdb3_sym_classify
  import hdb3_dec_pkg::*;
(
  input  logic      rail_p,
  input  logic      rail_n,
  output line_sym_t sym
);

  assign sym = line_sym_t'({rail_n, rail_p});

endmodule

// File: rtl/hdb3_polarity_tracker.sv
module hdb3_polarity_tracker
  import hdb3_dec_pkg::*;
#(
  parameter int RUN_LIMIT = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  line_sym_t sym,
  output dec_act_t  act
);

  localparam int ZW = $clog2(RUN_LIMIT + 2);
  localparam logic [ZW-1:0] RUN_SAT   = ZW'(RUN_LIMIT + 1);
  localparam logic [ZW-1:0] RUN_ALARM = ZW'(RUN_LIMIT);
  localparam logic [ZW-1:0] GAP_B00V  = ZW'(2);
  localparam logic [ZW-1:0] GAP_000V  = ZW'(3);

  logic          have_pol, nxt_have;
  logic          last_pos, nxt_pos;
  logic          tail_ok,  nxt_tail;   // last mark was a clean alternating one
  logic [ZW-1:0] zrun,     nxt_run;
  logic          is_pos;

  always_comb begin
    act      = '0;
    nxt_have = have_pol;
    nxt_pos  = last_pos;
    nxt_tail = tail_ok;
    nxt_run  = zrun;
    is_pos   = (sym == SYM_PLUS);
    case (sym)
      SYM_SPACE: begin
        if (zrun == RUN_ALARM) act.err = 1'b1;
        if (zrun != RUN_SAT)   nxt_run = zrun + 1'b1;
      end
      SYM_DOUBLE: begin
        act.mark_bit = 1'b1;
        act.err      = 1'b1;
        nxt_run      = '0;
        nxt_tail     = 1'b0;
      end
      default: begin
        nxt_have = 1'b1;
        nxt_pos  = is_pos;
        nxt_run  = '0;
        if (have_pol && (is_pos == last_pos)) begin
          if ((zrun == GAP_000V) || ((zrun == GAP_B00V) && tail_ok)) begin
            act.wipe = 1'b1;
          end else begin
            act.mark_bit = 1'b1;
            act.err      = 1'b1;
          end
          nxt_tail = 1'b0;
        end else begin
          act.mark_bit = 1'b1;
          nxt_tail     = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_pol <= 1'b0;
      last_pos <= 1'b0;
      tail_ok  <= 1'b0;
      zrun     <= '0;
    end else begin
      have_pol <= nxt_have;
      last_pos <= nxt_pos;
      tail_ok  <= nxt_tail;
      zrun     <= nxt_run;
    end
  end

endmodule

// File: rtl/hdb3_retime_pipe.sv
module hdb3_retime_pipe #(
  parameter int LATENCY   = 4,
  parameter int WIPE_SPAN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic in_bit,
  input  logic wipe,
  output logic out_bit
);

  logic [LATENCY-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage   <= '0;
      out_bit <= 1'b0;
    end else begin
      out_bit  <= stage[LATENCY-1];
      stage[0] <= in_bit;
      for (int i = 1; i < LATENCY; i++) begin
        stage[i] <= (wipe && (i < WIPE_SPAN)) ? 1'b0 : stage[i-1];
      end
    end
  end

endmodule

// File: rtl/hdb3_line_decoder.sv
module hdb3_line_decoder
  import hdb3_dec_pkg::*;
#(
  parameter int RUN_LIMIT = 4,
  parameter int LATENCY   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rail_p,
  input  logic rail_n,
  output logic nrz_out,
  output logic code_alarm
);

  localparam int SUB_LEN = 4;

  line_sym_t sym;
  dec_act_t  act;

  hdb3_sym_classify u_classify (
    .rail_p (rail_p),
    .rail_n (rail_n),
    .sym    (sym)
  );

  hdb3_polarity_tracker #(.RUN_LIMIT(RUN_LIMIT)) u_tracker (
    .clk (clk),
    .rst (rst),
    .sym (sym),
    .act (act)
  );

  hdb3_retime_pipe #(.LATENCY(LATENCY), .WIPE_SPAN(SUB_LEN)) u_pipe (
    .clk     (clk),
    .rst     (rst),
    .in_bit  (act.mark_bit),
    .wipe    (act.wipe),
    .out_bit (nrz_out)
  );

  always_ff @(posedge clk) begin
    if (rst) code_alarm <= 1'b0;
    else     code_alarm <= act.err;
  end

endmodule

// File: rtl/hdb3_line_decoder_chk.sv
module hdb3_line_decoder_chk (
  input logic clk,
  input logic rst,
  input logic rail_p,
  input logic rail_n,
  input logic nrz_out,
  input logic code_alarm
);

  assert_double_alarm_R8: assert property (@(posedge clk) disable iff (rst)
    (rail_p && rail_n) |=> code_alarm);

  assert_double_decodes_one_R8: assert property (@(posedge clk) disable iff (rst)
    (rail_p && rail_n) |-> ##5 nrz_out);

  assert_space_decodes_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (!rail_p && !rail_n) |-> ##5 !nrz_out);

  assert_alternation_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (rail_p && !rail_n && $past(rail_n && !rail_p)) |=> !code_alarm);

  assert_run_alarm_once_R9: assert property (@(posedge clk) disable iff (rst)
    (!rail_p && !rail_n && $past(!rail_p && !rail_n) && code_alarm) |=> !code_alarm);

endmodule

bind hdb3_line_decoder hdb3_line_decoder_chk i_chk (.*);

// File: tb/test_hdb3_line_decoder.sv
module test_hdb3_line_decoder;

  localparam int MAXS = 12000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rail_p = 1'b0;
  logic rail_n = 1'b0;
  logic nrz_out;
  logic code_alarm;

  int errors = 0;
  int checks = 0;
  int nstep  = 0;
  int base   = 0;
  bit done   = 1'b0;

  bit    exp_bit [MAXS];
  bit    exp_al  [MAXS];
  bit    al_on   [MAXS];
  string rqs     [MAXS];
  bit    src     [MAXS];
  int    code    [MAXS];

  always #10 clk = ~clk;

  hdb3_line_decoder i_hdb3_line_decoder (
    .clk        (clk),
    .rst        (rst),
    .rail_p     (rail_p),
    .rail_n     (rail_n),
    .nrz_out    (nrz_out),
    .code_alarm (code_alarm)
  );

  task automatic check1(input string rq, input logic act, input logic expv, input string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b (step %0d)", rq, what, act, expv, nstep);
    end
  endtask

  // Called at a falling edge; checks older steps, then presents a new symbol.
  task automatic drive(input logic p, input logic n, input logic eb, input logic ea,
                       input logic ca, input string rq);
    int s;
    s = nstep - 5;
    if (s >= base) check1(rqs[s], nrz_out, exp_bit[s], "nrz_out");
    s = nstep - 1;
    if (s >= base && al_on[s]) check1(rqs[s], code_alarm, exp_al[s], "code_alarm");
    rail_p = p;
    rail_n = n;
    exp_bit[nstep] = eb;
    exp_al[nstep]  = ea;
    al_on[nstep]   = ca;
    rqs[nstep]     = rq;
    nstep++;
    @(negedge clk);
  endtask

  // c: 0 space, 1 positive, 2 negative, 3 both rails
  task automatic sym(input int c, input logic eb, input logic ea, input string rq);
    drive(c == 1 || c == 3, c == 2 || c == 3, eb, ea, 1'b1, rq);
  endtask

  task automatic flush();
    for (int k = 0; k < 5; k++) drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
  endtask

  task automatic do_reset();
    rail_p = 1'b0;
    rail_n = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check1("R1", nrz_out, 1'b0, "nrz_out in reset");
    check1("R1", code_alarm, 1'b0, "code_alarm in reset");
    rst = 1'b0;
    base = nstep;
  endtask

  initial begin
    int nbits, i, ones;
    bit lp;
    @(negedge clk);

    // R2: polarity record forgotten by reset
    do_reset();
    sym(1, 1, 0, "R2");
    do_reset();
    sym(1, 1, 0, "R2");
    sym(2, 1, 0, "R2");
    flush();

    // R7: same polarity with no spaces, then one space
    do_reset();
    sym(1, 1, 0, "R7");
    sym(2, 1, 0, "R7");
    sym(2, 1, 1, "R7");
    sym(1, 1, 0, "R7");
    sym(0, 0, 0, "R7");
    sym(1, 1, 1, "R7");
    sym(2, 1, 0, "R4");
    flush();

    // R8: double rail keeps polarity
    do_reset();
    sym(1, 1, 0, "R8");
    sym(3, 1, 1, "R8");
    sym(2, 1, 0, "R8");
    flush();

    // R9: long space run, alarm once
    do_reset();
    sym(1, 1, 0, "R9");
    for (int k = 0; k < 4; k++) sym(0, 0, 0, "R9");
    sym(0, 0, 1, "R9");
    sym(0, 0, 0, "R4");
    sym(0, 0, 0, "R9");
    sym(2, 1, 0, "R9");
    flush();

    // R7: four spaces then same polarity is not a substitution
    do_reset();
    sym(1, 1, 0, "R7");
    for (int k = 0; k < 4; k++) sym(0, 0, 0, "R7");
    sym(1, 1, 1, "R7");
    flush();

    // R5: 000V
    do_reset();
    sym(1, 1, 0, "R5");
    for (int k = 0; k < 3; k++) sym(0, 0, 0, "R5");
    sym(1, 0, 0, "R5");
    sym(2, 1, 0, "R5");
    flush();

    // R6: B00V removes the B
    do_reset();
    sym(1, 1, 0, "R6");
    sym(2, 0, 0, "R6");
    sym(0, 0, 0, "R6");
    sym(0, 0, 0, "R6");
    sym(2, 0, 0, "R6");
    sym(1, 1, 0, "R6");
    flush();

    // R6: two spaces after a substitution are not B00V
    do_reset();
    sym(1, 1, 0, "R6");
    for (int k = 0; k < 3; k++) sym(0, 0, 0, "R6");
    sym(1, 0, 0, "R5");
    sym(0, 0, 0, "R6");
    sym(0, 0, 0, "R6");
    sym(1, 1, 1, "R6");
    flush();

    // R10 / R3: every 10-bit word, HDB3 encoded, back to back
    do_reset();
    nbits = 0;
    src[nbits++] = 1'b1;
    for (int w = 0; w < 1024; w++)
      for (int k = 0; k < 10; k++) src[nbits++] = bit'((w >> k) & 1);
    for (int k = 0; k < 8; k++) src[nbits++] = 1'b1;
    lp = 1'b0;
    ones = 0;
    i = 0;
    while (i < nbits) begin
      if (src[i]) begin
        lp = !lp;
        code[i] = lp ? 1 : 2;
        ones++;
        i++;
      end else if (i + 3 < nbits && !src[i+1] && !src[i+2] && !src[i+3]) begin
        if (ones % 2 == 0) begin
          lp = !lp;
          code[i] = lp ? 1 : 2;
        end else begin
          code[i] = 0;
        end
        code[i+1] = 0;
        code[i+2] = 0;
        code[i+3] = lp ? 1 : 2;
        ones = 0;
        i += 4;
      end else begin
        code[i] = 0;
        i++;
      end
    end
    for (int k = 0; k < nbits; k++) sym(code[k], src[k], 1'b0, "R10");
    flush();

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule